// File: doc/BRIEF.md
# Palette and Oscillator Waveform Generator

This block holds a 256-entry table of 32-bit words. Each word is split into four 8-bit lanes that feed four DAC converters at the same time. A source other than the processor steps through the table, so waveforms run with no processor involvement. There are two sources:

- **Pixel mode.** The table acts as a palette. Packed pixel words arrive on a valid/ready handshake. They are unpacked least-significant pixel first, one pixel per output enable. Each pixel is 1, 2, 4 or 8 bits wide.
- **Oscillator mode.** A free-running phase accumulator adds a frequency word on every clock. The top eight bits of the phase select the entry. This gives a background function generator.

The processor can rewrite table entries at any time through a write-only port, including while output is running.

Top module: `lut_wavegen`

## Requirements
- R1: While reset is active and after it is released, the lane outputs are all zero and `pix_ready_o` is 1.
- R2: A write through the table port stores 32 bits at the given address. The stored value appears on the lanes the next time that address is selected.
- R3: Lane k carries bits 8k+7 down to 8k of the selected entry. Lane 0 carries the low byte.
- R4: With `src_nco_i` = 1, a 32-bit phase (0 after reset) adds `nco_freq_i` on every clock. Each clock loads the entry at the phase's top eight bits into the lanes, which show it one clock later. The phase holds its value while `src_nco_i` = 0.
- R5: `pix_depth_i` selects the pixel width: 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8. A 32-bit word then holds 32 / width pixels, and each pixel value is the table index.
- R6: With `src_nco_i` = 0, each clock with `pix_en_i` high consumes the next pixel, starting at bit 0. Its entry appears on the lanes one clock later. While `pix_en_i` is low the lanes hold.
- R7: `pix_ready_o` is high exactly when no pixels remain. A word is taken on a clock where `pix_valid_i` and `pix_ready_o` are both high. `pix_ready_o` is low from the next clock until the clock after the last pixel is consumed.
- R8: When a table write and a read of the same entry happen in the same clock, the lanes receive the old value. The new value is returned from the next read onward.
- R9: In pixel mode with no word held, `pix_en_i` has no effect and the lanes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_nco_i | input | 1 | 1 = oscillator drives the index, 0 = pixel stream |
| pix_depth_i | input | 2 | Pixel width code (1/2/4/8 bits) |
| nco_freq_i | input | 32 | Phase increment per clock |
| pix_word_i | input | 32 | Packed pixel word |
| pix_valid_i | input | 1 | Pixel word offered |
| pix_ready_o | output | 1 | Shifter empty, a word is requested |
| pix_en_i | input | 1 | Consume one pixel this clock |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 8 | Table write address |
| tbl_data_i | input | 32 | Table write data |
| dac_o | output | 4x8 | Four DAC lanes, lane 0 in bits 7:0 |

## Verification
Every lane result is due exactly one clock after the edge that consumed its pixel or oscillator phase. `pix_ready_o` changes on that same edge.

The driver changes inputs only on falling edges. With each stimulus it records an expected item due one edge later. The monitor samples just after each rising edge and compares items whose due count has been reached.

Write collisions, idle enables and empty-shifter enables each queue a "hold" or "old value" expectation for that same single-cycle slot.

// File: rtl/lut_wavegen_pkg.sv
package lut_wavegen_pkg;
  typedef enum logic {SRC_PIXEL = 1'b0, SRC_NCO = 1'b1} src_e;
  typedef enum logic [1:0] {BPP_1 = 2'd0, BPP_2 = 2'd1, BPP_4 = 2'd2, BPP_8 = 2'd3} bpp_e;
endpackage

// File: rtl/lut_wavegen_nco.sv
module lut_wavegen_nco #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] freq_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (run_i) phase_q <= phase_q + freq_i;
  end

  assign idx_o = phase_q[PHASE_W-1 -: IDX_W];
endmodule

// File: rtl/lut_wavegen_shifter.sv
module lut_wavegen_shifter #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [1:0]        depth_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              en_i,
  output logic              fire_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  bits_w;
  logic [CNT_W-1:0]  cnt_load_w;
  logic [IDX_W:0]    mask_w;
  logic              empty_w;

  assign empty_w    = (cnt_q == '0);
  assign bits_w     = CNT_W'(1) << depth_i;
  assign cnt_load_w = CNT_W'(WORD_W) >> depth_i;
  assign mask_w     = ((IDX_W+1)'(1) << bits_w) - (IDX_W+1)'(1);
  assign idx_o      = sh_q[IDX_W-1:0] & mask_w[IDX_W-1:0];
  assign ready_o    = empty_w;
  assign fire_o     = active_i && en_i && !empty_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (valid_i && empty_w) begin
      sh_q  <= word_i;
      cnt_q <= cnt_load_w;
    end else if (fire_o) begin
      sh_q  <= sh_q >> bits_w;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/lut_wavegen_table.sv
module lut_wavegen_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read sees pre-write contents on a same-edge collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/lut_wavegen.sv
module lut_wavegen
  import lut_wavegen_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 8,
  parameter int LANES   = 4,
  parameter int PHASE_W = 32,
  parameter int WORD_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          src_nco_i,
  input  logic [1:0]                    pix_depth_i,
  input  logic [PHASE_W-1:0]            nco_freq_i,
  input  logic [WORD_W-1:0]             pix_word_i,
  input  logic                          pix_valid_i,
  output logic                          pix_ready_o,
  input  logic                          pix_en_i,
  input  logic                          tbl_we_i,
  input  logic [ADDR_W-1:0]             tbl_addr_i,
  input  logic [LANES*LANE_W-1:0]       tbl_data_i,
  output logic [LANES-1:0][LANE_W-1:0]  dac_o
);
  localparam int ENTRY_W = LANES * LANE_W;

  src_e              src_w;
  logic [ADDR_W-1:0] nco_idx_w;
  logic [ADDR_W-1:0] pix_idx_w;
  logic [ADDR_W-1:0] rd_idx_w;
  logic              pix_fire_w;
  logic              rd_en_w;
  logic [ENTRY_W-1:0] entry_w;

  assign src_w = src_e'(src_nco_i);

  lut_wavegen_nco #(.PHASE_W(PHASE_W), .IDX_W(ADDR_W)) u_nco (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (src_w == SRC_NCO),
    .freq_i (nco_freq_i),
    .idx_o  (nco_idx_w)
  );

  lut_wavegen_shifter #(.WORD_W(WORD_W), .IDX_W(ADDR_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (src_w == SRC_PIXEL),
    .depth_i  (pix_depth_i),
    .word_i   (pix_word_i),
    .valid_i  (pix_valid_i),
    .ready_o  (pix_ready_o),
    .en_i     (pix_en_i),
    .fire_o   (pix_fire_w),
    .idx_o    (pix_idx_w)
  );

  always_comb begin
    if (src_w == SRC_NCO) begin
      rd_idx_w = nco_idx_w;
      rd_en_w  = 1'b1;
    end else begin
      rd_idx_w = pix_idx_w;
      rd_en_w  = pix_fire_w;
    end
  end

  lut_wavegen_table #(.ADDR_W(ADDR_W), .DATA_W(ENTRY_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we_i),
    .wr_addr_i (tbl_addr_i),
    .wr_data_i (tbl_data_i),
    .rd_en_i   (rd_en_w),
    .rd_addr_i (rd_idx_w),
    .rd_data_o (entry_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dac_o[g] = entry_w[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lut_wavegen_chk.sv
module lut_wavegen_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               src_nco_i,
  input logic [PHASE_W-1:0] nco_freq_i,
  input logic               pix_valid_i,
  input logic               pix_ready_o,
  input logic               pix_en_i,
  input logic               tbl_we_i,
  input logic [OUT_W-1:0]   dac_i
);
  p_ready_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_ready_o) |=> !pix_ready_o);

  p_ready_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_ready_o && (src_nco_i || !pix_en_i)) |=> !pix_ready_o);

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_nco_i && !pix_en_i) |=> $stable(dac_i));

  p_empty_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_nco_i && pix_ready_o) |=> $stable(dac_i));

  p_nco_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_nco_i && $past(src_nco_i) && nco_freq_i == '0 && $past(nco_freq_i) == '0
     && !$past(tbl_we_i)) |=> $stable(dac_i));
endmodule

bind lut_wavegen lut_wavegen_chk #(.PHASE_W(PHASE_W), .OUT_W(LANES*LANE_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_nco_i   (src_nco_i),
  .nco_freq_i  (nco_freq_i),
  .pix_valid_i (pix_valid_i),
  .pix_ready_o (pix_ready_o),
  .pix_en_i    (pix_en_i),
  .tbl_we_i    (tbl_we_i),
  .dac_i       (dac_o)
);

// File: tb/test_lut_wavegen.sv
`timescale 1ns/1ps
module test_lut_wavegen;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            src_nco_i = 1'b0;
  logic [1:0]      pix_depth_i = 2'd3;
  logic [31:0]     nco_freq_i = '0;
  logic [31:0]     pix_word_i = '0;
  logic            pix_valid_i = 1'b0;
  logic            pix_ready_o;
  logic            pix_en_i = 1'b0;
  logic            tbl_we_i = 1'b0;
  logic [7:0]      tbl_addr_i = '0;
  logic [31:0]     tbl_data_i = '0;
  logic [3:0][7:0] dac_o;

  lut_wavegen i_lut_wavegen (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int          due;
    bit          is_rdy;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] tbl_m [256];
  logic [31:0] last_m = '0;
  logic [31:0] ph_m = '0;

  function automatic logic [31:0] pat(int i);
    return {8'(i ^ 8'hA5), 8'(i * 3), 8'(~i), 8'(i)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(bit rdy, logic [31:0] e, string req);
    item_t it;
    it.due = cyc + 1; it.is_rdy = rdy; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: samples 1 ns after each rising edge
  initial forever begin
    @(posedge clk_i);
    #1;
    if (rst_ni) cyc++;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.is_rdy) check(it.req, {31'b0, pix_ready_o}, it.exp);
      else           check(it.req, dac_o, it.exp);
    end
  end

  task automatic send_word(logic [1:0] depth, logic [31:0] word);
    @(negedge clk_i);
    pix_depth_i = depth; pix_word_i = word; pix_valid_i = 1'b1; pix_en_i = 1'b0;
    push(1, 32'd0, "R7");
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic play(logic [1:0] depth, logic [31:0] word, int gap);
    int          n;
    int          bits;
    logic [31:0] w;
    n = 32 >> depth; bits = 1 << depth; w = word;
    for (int k = 0; k < n; k++) begin
      int idx;
      @(negedge clk_i);
      pix_en_i = 1'b1;
      idx = int'(w & ((32'd1 << bits) - 32'd1));
      w = w >> bits;
      last_m = tbl_m[idx];
      push(0, last_m, "R5");
      push(1, (k == n - 1) ? 32'd1 : 32'd0, "R7");
      if (gap > 0 && (k % gap) == 1) begin
        @(negedge clk_i);
        pix_en_i = 1'b0;
        push(0, last_m, "R6");
      end
    end
    @(negedge clk_i);
    pix_en_i = 1'b1;
    push(0, last_m, "R9");
    push(1, 32'd1, "R7");
    @(negedge clk_i);
    pix_en_i = 1'b0;
  endtask

  task automatic run_nco(logic [31:0] f, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      src_nco_i = 1'b1; nco_freq_i = f;
      last_m = tbl_m[ph_m[31:24]];
      push(0, last_m, "R4");
      ph_m = ph_m + f;
    end
  endtask

  initial begin
    #100000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", dac_o, 32'd0);
    check("R1", {31'b0, pix_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", dac_o, 32'd0);
    check("R1", {31'b0, pix_ready_o}, 32'd1);

    // R2: load every entry
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      tbl_we_i = 1'b1; tbl_addr_i = 8'(i); tbl_data_i = pat(i); tbl_m[i] = pat(i);
    end
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    push(0, 32'd0, "R9");

    send_word(2'd3, 32'h80_FF_01_3C);
    play(2'd3, 32'h80_FF_01_3C, 2);
    @(negedge clk_i);
    for (int l = 0; l < 4; l++) check("R3", 32'(dac_o[l]), 32'(last_m[l*8 +: 8]));

    send_word(2'd2, 32'h7E5A_0C93);
    play(2'd2, 32'h7E5A_0C93, 3);
    send_word(2'd1, 32'hE4B1_1B4E);
    play(2'd1, 32'hE4B1_1B4E, 5);
    send_word(2'd0, 32'hA5C3_0F69);
    play(2'd0, 32'hA5C3_0F69, 7);

    // R8: same-clock write and read of entry 9
    send_word(2'd3, 32'h09_09_09_09);
    @(negedge clk_i);
    pix_en_i = 1'b1; tbl_we_i = 1'b1; tbl_addr_i = 8'd9; tbl_data_i = 32'hDEAD_BEEF;
    push(0, tbl_m[9], "R8");
    tbl_m[9] = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      tbl_we_i = 1'b0;
      push(0, tbl_m[9], "R2");
    end
    @(negedge clk_i);
    pix_en_i = 1'b0;
    last_m = tbl_m[9];

    run_nco(32'h0312_3457, 40);
    run_nco(32'h0080_0000, 20);
    run_nco(32'h0000_0000, 5);
    run_nco(32'hF100_0001, 20);
    @(negedge clk_i);
    src_nco_i = 1'b0;
    push(0, last_m, "R4");
    @(negedge clk_i);
    src_nco_i = 1'b1; nco_freq_i = 32'h0100_0000;
    push(0, tbl_m[ph_m[31:24]], "R4");
    ph_m = ph_m + 32'h0100_0000;
    run_nco(32'h0100_0000, 4);

    repeat (4) @(negedge clk_i);
    if (sb_q.size() != 0) check("R6", 32'(sb_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule